// File: doc/BRIEF.md
# Programmable Timebase Interrupt Generator

This block turns a stream of sample-clock enables into the timing events for a set of correlator channels. A wrapping counter raises a periodic interrupt that paces accumulator transfers to the processor. A second, longer counter produces the measurement strobe (TIC). TIC marks the instant when all channels latch their measurement data. The same counter also drives a measurement interrupt and a one-millisecond time-mark pulse. The measurement interrupt fires at every TIC and once more a fixed lead time before it, so software gets an early warning.

Software programs both periods through a small write port. The TIC period is split across a high word and a low word. A programmed value waits in a shadow register and becomes active only when the running count wraps, so the current interval always completes at its old length. The interrupts are sticky flags. A status read returns the flags and clears them. A configuration input selects which of the two status addresses clears the measurement interrupt.

The defaults match a 5.714 MHz enable rate:
- accumulator interval of 2886 enables (about 505 µs),
- TIC interval of 571428 enables (about 100 ms),
- early-warning lead of 285714 enables (50 ms),
- time-mark width of 5714 enables (1 ms).

Top module: `timebase_gen`

## Requirements
- R1: While the accumulator period P is active, the accumulator interrupt becomes pending one clock after every P-th sample enable. P is 2886 after reset.
- R2: `tic_strobe` is high for exactly one clock, the clock after every T-th sample enable, where T is the active TIC period (571428 after reset). T is formed from two writes: address 1 sets bits T[19:16] from `wr_data[3:0]`, and address 2 sets T[15:0] from `wr_data[15:0]`.
- R3: A write to address 0 sets the next accumulator period from `wr_data`. A new accumulator or TIC period takes effect only when the running count wraps. A stored value of zero is ignored, and the previous period stays active.
- R4: A read of address 0 returns the accumulator-pending flag in bit 15 and the measurement-pending flag in bit 14. A read of address 1 returns the measurement-pending flag in bit 15. All other bits, other addresses, and idle cycles (`rd_en` low) return zero.
- R5: A read of address 0 drops `accum_irq` on the next clock. If an accumulator event falls in the same clock as that read, the flag stays set.
- R6: `meas_irq` becomes pending at every TIC. When T exceeds the lead L (default 285714), it also becomes pending L sample enables before each TIC. When T is L or less, it fires only at TIC.
- R7: `meas_irq` is cleared by a read of address 0 when `meas_clr_sel` is 0, and by a read of address 1 when it is 1. A read of the other address leaves it pending. An event coinciding with the clearing read keeps it set.
- R8: `time_mark` goes high together with `tic_strobe` and stays high for MARK_LEN sample enables (5714 by default). A new TIC restarts it.
- R9: During and after reset all outputs are low, both counts are zero, and the default periods are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_en | input | 1 | One-clock sample-clock enable; advances both counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 accumulator period, 1 TIC high, 2 TIC low |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Status read strobe; clears the flags it reads |
| rd_addr | input | 2 | Read address: 0 main status, 1 measurement status |
| meas_clr_sel | input | 1 | Selects which status address clears the measurement flag |
| rd_data | output | 16 | Status word, valid in the clock of the read |
| accum_irq | output | 1 | Sticky accumulator-transfer interrupt |
| tic_strobe | output | 1 | One-clock measurement latch strobe |
| meas_irq | output | 1 | Sticky measurement interrupt |
| time_mark | output | 1 | Time-mark pulse following each TIC |

## Verification
The hardest case to reach is a change to the high word of the TIC period. Its effect shows only after a wrap, and with a 16-bit-plus period the next wrap is tens of thousands of enables away. The bench writes high word 1, waits through the full 65541-enable interval, and then watches both the early warning and the TIC. It then reprograms a short period and waits for the long interval to finish. The other hard cases are the clear-on-read races and the period thresholds:
- Reads at random addresses, with random timing, land in the same clock as accumulator events, early warnings and TICs.
- The TIC period is set just above, equal to, and below the lead, to probe the strict threshold.

// File: rtl/timebase_pkg.sv
// Package: shared register addresses and status bit positions for the
// timebase generator. Assumes a 16-bit register data path.
package timebase_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        WA_ACC_PERIOD = 2'd0,
        WA_TIC_HIGH   = 2'd1,
        WA_TIC_LOW    = 2'd2,
        WA_SPARE      = 2'd3
    } wr_addr_e;

    typedef enum logic [1:0] {
        RA_MAIN_STATUS = 2'd0,
        RA_MEAS_STATUS = 2'd1,
        RA_SPARE2      = 2'd2,
        RA_SPARE3      = 2'd3
    } rd_addr_e;

    localparam int BIT_ACC_PEND  = 15;
    localparam int BIT_MEAS_MAIN = 14;
    localparam int BIT_MEAS_PEND = 15;

endpackage

// File: rtl/tbase_wrap_counter.sv
// Wrapping interval counter with a shadowed period.
// Counts enable pulses from 0 to period-1. On the wrap it reloads its active
// period from next_period, unless next_period is zero (then the old one stays).
// Assumes INIT is nonzero.
module tbase_wrap_counter #(
    parameter int W = 16,
    parameter logic [W-1:0] INIT = W'(1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] next_period,
    output logic [W-1:0] count,
    output logic [W-1:0] period,
    output logic         wrap
);

    // Terminal-count detect on the enabled step.
    always_comb begin
        wrap = step && (count == period - W'(1));
    end

    // Advance the count; swap in the shadow period at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            period <= INIT;
        end else if (step) begin
            if (wrap) begin
                count <= '0;
                if (next_period != '0) begin
                    period <= next_period;
                end
            end else begin
                count <= count + W'(1);
            end
        end
    end

endmodule

// File: rtl/tbase_sticky_flag.sv
// Sticky pending flag with clear-on-read.
// A set in the same clock as a clear wins, so no event is lost.
module tbase_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Hold the flag until cleared; a new event overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= set | (q & ~clr);
        end
    end

endmodule

// File: rtl/tbase_pulse_stretch.sv
// Retriggerable pulse stretcher measured in enable pulses.
// A trigger loads LEN; each step then counts down while the count is nonzero.
// The output is high while the count is nonzero. Assumes LEN >= 1.
module tbase_pulse_stretch #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic step,
    output logic active
);

    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] remain;

    // Load on trigger, otherwise count down on each enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (trig) begin
            remain <= LOAD;
        end else if (step && remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    // The pulse lasts while enables remain.
    always_comb begin
        active = (remain != '0);
    end

endmodule

// File: rtl/timebase_gen.sv
// Top: programmable timebase generator.
// Two interval counters run on the sample enable. The accumulator counter drives
// a sticky interrupt. The TIC counter drives a one-clock strobe, a sticky
// measurement interrupt (at TIC and LEAD enables before it) and a time-mark
// pulse. Writes go to shadow registers; status reads clear the flags they
// report.
// Assumes: ACC_W <= 16, 16 < TIC_W <= 32, and nonzero defaults.
module timebase_gen #(
    parameter int ACC_W       = 16,
    parameter int TIC_W       = 20,
    parameter int ACC_DEFAULT = 2886,
    parameter int TIC_DEFAULT = 571428,
    parameter int LEAD        = 285714,
    parameter int MARK_LEN    = 5714
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        samp_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    input  logic [1:0]  rd_addr,
    input  logic        meas_clr_sel,
    output logic [15:0] rd_data,
    output logic        accum_irq,
    output logic        tic_strobe,
    output logic        meas_irq,
    output logic        time_mark
);
    import timebase_pkg::*;

    localparam int HI_W = TIC_W - 16;
    localparam logic [ACC_W-1:0] ACC_INIT = ACC_W'(ACC_DEFAULT);
    localparam logic [TIC_W-1:0] TIC_INIT = TIC_W'(TIC_DEFAULT);
    localparam logic [TIC_W-1:0] LEAD_V   = TIC_W'(LEAD);

    logic [ACC_W-1:0] acc_shadow;
    logic [HI_W-1:0]  tic_hi_shadow;
    logic [15:0]      tic_lo_shadow;

    logic [ACC_W-1:0] acc_count, acc_period;
    logic [TIC_W-1:0] tic_count, tic_period;
    logic             acc_wrap, tic_wrap;
    logic             early_hit;
    logic [TIC_W-1:0] early_point;
    logic             rd_main, rd_meas, clr_meas;

    // Capture register writes into the shadow periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_shadow    <= ACC_INIT;
            tic_hi_shadow <= TIC_INIT[TIC_W-1:16];
            tic_lo_shadow <= TIC_INIT[15:0];
        end else if (wr_en) begin
            unique case (wr_addr_e'(wr_addr))
                WA_ACC_PERIOD: acc_shadow    <= wr_data[ACC_W-1:0];
                WA_TIC_HIGH:   tic_hi_shadow <= wr_data[HI_W-1:0];
                WA_TIC_LOW:    tic_lo_shadow <= wr_data;
                default:       ;
            endcase
        end
    end

    tbase_wrap_counter #(.W(ACC_W), .INIT(ACC_INIT)) u_acc_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (samp_en),
        .next_period (acc_shadow),
        .count       (acc_count),
        .period      (acc_period),
        .wrap        (acc_wrap)
    );

    tbase_wrap_counter #(.W(TIC_W), .INIT(TIC_INIT)) u_tic_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (samp_en),
        .next_period ({tic_hi_shadow, tic_lo_shadow}),
        .count       (tic_count),
        .period      (tic_period),
        .wrap        (tic_wrap)
    );

    // Early-warning point: LEAD enables before the wrap, only if the period exceeds LEAD.
    always_comb begin
        early_point = tic_period - TIC_W'(1) - LEAD_V;
        early_hit   = samp_en && (tic_period > LEAD_V) && (tic_count == early_point);
    end

    // Decode which status read clears which flag.
    always_comb begin
        rd_main  = rd_en && (rd_addr_e'(rd_addr) == RA_MAIN_STATUS);
        rd_meas  = rd_en && (rd_addr_e'(rd_addr) == RA_MEAS_STATUS);
        clr_meas = meas_clr_sel ? rd_meas : rd_main;
    end

    tbase_sticky_flag u_acc_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (acc_wrap),
        .clr   (rd_main),
        .q     (accum_irq)
    );

    tbase_sticky_flag u_meas_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (tic_wrap | early_hit),
        .clr   (clr_meas),
        .q     (meas_irq)
    );

    // Register the TIC wrap into a one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tic_strobe <= 1'b0;
        end else begin
            tic_strobe <= tic_wrap;
        end
    end

    tbase_pulse_stretch #(.LEN(MARK_LEN)) u_mark (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (tic_wrap),
        .step   (samp_en),
        .active (time_mark)
    );

    // Status word for the current read; zero when idle.
    always_comb begin
        rd_data = '0;
        if (rd_main) begin
            rd_data[BIT_ACC_PEND]  = accum_irq;
            rd_data[BIT_MEAS_MAIN] = meas_irq;
        end else if (rd_meas) begin
            rd_data[BIT_MEAS_PEND] = meas_irq;
        end
    end

endmodule

// File: rtl/timebase_gen_chk.sv
// Checker for timebase_gen, attached by bind. It watches ports and counter
// state and holds no logic of its own.
module timebase_gen_chk #(
    parameter int ACC_W = 16,
    parameter int TIC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_en,
    input logic             rd_en,
    input logic [1:0]       rd_addr,
    input logic             meas_clr_sel,
    input logic             accum_irq,
    input logic             tic_strobe,
    input logic             meas_irq,
    input logic             time_mark,
    input logic [ACC_W-1:0] acc_count,
    input logic [ACC_W-1:0] acc_period,
    input logic [TIC_W-1:0] tic_count,
    input logic [TIC_W-1:0] tic_period
);

    assert_acc_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_count < acc_period);

    assert_tic_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tic_count < tic_period);

    assert_tic_after_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tic_strobe |-> $past(samp_en));

    assert_acc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accum_irq && !(rd_en && rd_addr == 2'd0)) |=> accum_irq);

    assert_meas_at_tic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tic_strobe |-> meas_irq);

    assert_meas_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_irq && !(rd_en && rd_addr == (meas_clr_sel ? 2'd1 : 2'd0))) |=> meas_irq);

    assert_mark_with_tic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tic_strobe |-> time_mark);

    assert_mark_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (time_mark && !samp_en) |=> time_mark);

endmodule

bind timebase_gen timebase_gen_chk #(.ACC_W(ACC_W), .TIC_W(TIC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_en      (samp_en),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .meas_clr_sel (meas_clr_sel),
    .accum_irq    (accum_irq),
    .tic_strobe   (tic_strobe),
    .meas_irq     (meas_irq),
    .time_mark    (time_mark),
    .acc_count    (acc_count),
    .acc_period   (acc_period),
    .tic_count    (tic_count),
    .tic_period   (tic_period)
);

// File: tb/test_timebase_gen.sv
// Bench: a behavioural reference model updated on every rising edge and
// compared against the design on every falling edge.
module test_timebase_gen;

    localparam int ACC_DEF = 12;
    localparam int TIC_DEF = 90;
    localparam int LEAD_N  = 30;
    localparam int MARK_N  = 6;
    localparam int WDOG    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic        meas_clr_sel = 1'b0;
    logic [15:0] rd_data;
    logic        accum_irq, tic_strobe, meas_irq, time_mark;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    int cyc = 0;

    // reference model state
    int  m_acc_cnt, m_acc_per, m_acc_sh;
    int  m_tic_cnt, m_tic_per, m_tic_sh;
    bit  m_acc, m_meas, m_tic;
    int  m_mark;

    always #4 clk = ~clk;

    timebase_gen #(
        .ACC_W(16), .TIC_W(20), .ACC_DEFAULT(ACC_DEF), .TIC_DEFAULT(TIC_DEF),
        .LEAD(LEAD_N), .MARK_LEN(MARK_N)
    ) i_timebase_gen (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .meas_clr_sel(meas_clr_sel), .rd_data(rd_data), .accum_irq(accum_irq),
        .tic_strobe(tic_strobe), .meas_irq(meas_irq), .time_mark(time_mark)
    );

    // Reference model: advance on every rising edge from the driven inputs.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_acc_cnt = 0; m_acc_per = ACC_DEF; m_acc_sh = ACC_DEF;
            m_tic_cnt = 0; m_tic_per = TIC_DEF; m_tic_sh = TIC_DEF;
            m_acc = 0; m_meas = 0; m_tic = 0; m_mark = 0;
        end else begin
            bit acc_ev, tic_ev, early_ev, clr_a, clr_m;
            acc_ev   = samp_en && (m_acc_cnt == m_acc_per - 1);
            tic_ev   = samp_en && (m_tic_cnt == m_tic_per - 1);
            early_ev = samp_en && (m_tic_per > LEAD_N) && (m_tic_cnt == m_tic_per - 1 - LEAD_N);
            clr_a    = rd_en && rd_addr == 2'd0;
            clr_m    = rd_en && (meas_clr_sel ? rd_addr == 2'd1 : rd_addr == 2'd0);
            m_acc  = acc_ev || (m_acc && !clr_a);
            m_meas = tic_ev || early_ev || (m_meas && !clr_m);
            m_tic  = tic_ev;
            if (tic_ev) m_mark = MARK_N;
            else if (samp_en && m_mark > 0) m_mark--;
            if (samp_en) begin
                if (acc_ev) begin
                    m_acc_cnt = 0;
                    if (m_acc_sh != 0) m_acc_per = m_acc_sh;
                end else m_acc_cnt++;
                if (tic_ev) begin
                    m_tic_cnt = 0;
                    if (m_tic_sh != 0) m_tic_per = m_tic_sh;
                end else m_tic_cnt++;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_acc_sh = int'(wr_data);
                    2'd1: m_tic_sh = ((int'(wr_data) & 32'hF) << 16) | (m_tic_sh & 32'hFFFF);
                    2'd2: m_tic_sh = (m_tic_sh & 32'hF0000) | int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare the registered outputs against the model (falling edge, before driving).
    task automatic cmp_regs();
        chk(accum_irq == m_acc, "R1/R5 accum_irq", accum_irq, m_acc);
        chk(tic_strobe == m_tic, "R2 tic_strobe", tic_strobe, m_tic);
        chk(meas_irq == m_meas, "R6/R7 meas_irq", meas_irq, m_meas);
        chk(time_mark == (m_mark > 0), "R8 time_mark", time_mark, m_mark > 0);
    endtask

    // Compare the status word for the inputs just driven.
    task automatic cmp_read();
        int exp;
        exp = 0;
        if (rd_en && rd_addr == 2'd0) exp = (int'(m_acc) << 15) | (int'(m_meas) << 14);
        else if (rd_en && rd_addr == 2'd1) exp = int'(m_meas) << 15;
        chk(int'(rd_data) == exp, "R4 rd_data", rd_data, exp);
    endtask

    // Run n cycles: mode 0 enables every clock, 1 every third, 2 random.
    task automatic run(input int n, input int mode, input int rd_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_regs();
            wr_en   = 1'b0;
            samp_en = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 == 0) : ($urandom % 2 == 0);
            rd_en   = ($urandom % 100) < rd_pct;
            rd_addr = 2'($urandom % 3);
            #1 cmp_read();
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cmp_regs();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        samp_en = 1'b1; rd_en = 1'b0;
        #1 cmp_read();
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", WDOG, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_regs();
        chk(rd_data == 16'h0, "R9 rd_data in reset", rd_data, 0);
        rst_n = 1'b1;
        // R1 R2 R6 R8: default periods, enable every clock, light reads
        run(400, 0, 5);
        // pattern of sparse and random enables with heavier reads (R5 R7 races)
        run(600, 1, 15);
        run(600, 2, 25);
        // R3: new periods, applied at the next wrap
        wr(2'd0, 16'd7);
        wr(2'd2, 16'd40);
        run(300, 0, 20);
        // R7: select the second status address for clearing
        meas_clr_sel = 1'b1;
        run(300, 2, 30);
        // R6: period below lead, then equal to lead (no early warning)
        wr(2'd2, 16'd25);
        run(200, 0, 10);
        wr(2'd2, 16'd30);
        run(200, 0, 10);
        meas_clr_sel = 1'b0;
        // R3: a zero period is ignored
        wr(2'd0, 16'd0);
        run(150, 0, 10);
        // R2: high word, a period of 65541 enables
        wr(2'd0, 16'd9);
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd5);
        run(66000, 0, 1);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd40);
        run(65700, 0, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule